// File: doc/BRIEF.md
# Windowed Input Clock Presence Detector

This block decides whether an external clock is alive and running at roughly the frequency it should. A timer in the reference clock domain marks out a measurement window whose length is set in units of eight reference cycles. A counter in the monitored clock domain counts rising edges of that clock. At each window end the count is carried into the reference domain through a toggle request/acknowledge handshake and compared with a programmable expected value. The clock-ok flag is raised when the count reaches the expected value and cleared when it falls short or when the monitored clock has stopped.

Configuration is written through a small register-style port with two words. The detector word holds the window length, the expected edge count, a detection enable and a software force that pins clock-ok high. The lock word holds an enable and a value that, when enabled, replace an incoming PLL lock indication. Both words read back on the same port. The flag is published once per window with one window of latency, and the first two windows after enabling or reconfiguring only prime the measurement path.

Top module: `clk_presence_mon`

## Requirements
- R1: After reset, the detector word (select 0) reads 0x100D and the lock word (select 1) reads 0x0000, and clk_ok is 0. Detector word fields: bits [4:0] window length, [12:5] expected count, [13] detection enable, [14] force-ok. Lock word fields: bit 0 bypass enable, bit 1 bypass value.
- R2: A window lasts 8 x L reference cycles, where L is the window length field, and a field value of 0 is treated as 1.
- R3: With detection enabled, at each published window end clk_ok becomes 1 if the monitored-clock rising edges counted in the preceding complete window are at least the expected count, and 0 otherwise.
- R4: The edge counter saturates at 255 rather than wrapping, so a clock with more edges per window than 255 still satisfies an expected count of 255.
- R5: While detection is disabled and force-ok is 0, clk_ok is 0 within two reference cycles of the write.
- R6: If the monitored clock stops, clk_ok falls to 0 no later than the second window end after the stop.
- R7: clk_ok changes only at window ends (or on disable, or through force-ok). After detection is enabled, the first result is published at the end of the third window.
- R8: When force-ok is 1, clk_ok is 1 regardless of the measurement and of the enable bit.
- R9: Writing a different window length or expected count while detection is enabled restarts the window; clk_ok keeps its previous value until a new result is published at the end of the third window after the write.
- R10: When bypass enable is 1, pll_lock equals the bypass value; when it is 0, pll_lock follows pll_lock_in.
- R11: A new count request is issued only after the previous one has been acknowledged; at a window end with a request still outstanding, the result published is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; timer, configuration and results |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_mon | input | 1 | Monitored input clock |
| cfg_wr | input | 1 | Write strobe for the configuration word selected by cfg_sel |
| cfg_sel | input | 1 | Word select: 0 detector word, 1 lock word |
| cfg_wdata | input | 15 | Write data |
| cfg_rdata | output | 15 | Read data of the selected word |
| pll_lock_in | input | 1 | Incoming PLL lock indication |
| clk_ok | output | 1 | Monitored clock present at the expected rate |
| pll_lock | output | 1 | PLL lock indication after the bypass |

## Verification
The bench sweeps window lengths 0, 2, 4 and 13 against four monitored-clock periods and, for each pair, sets the expected count a quarter below and a quarter above the arithmetic edge count, so a window of the wrong length or a count taken from a partial window flips one of the two results. A clock with 277 edges per window against an expected 255 catches a wrapping counter, which would report 21 edges and drop the flag. Stopping the monitored clock catches a handshake that waits forever on a dead domain and leaves the flag stuck high. Probes at two and a half and three and a half windows after enabling or reconfiguring catch a design that publishes a stale or partial first count or that clears the flag early on a restart.

// File: rtl/clkdet_pkg.sv
package clkdet_pkg;

  localparam int LEN_W = 5;
  localparam int EXP_W = 8;
  localparam int CNT_W = EXP_W;

  typedef struct packed {
    logic             force_ok;
    logic             det_en;
    logic [EXP_W-1:0] exp_cnt;
    logic [LEN_W-1:0] win_len;
  } det_cfg_t;

  typedef struct packed {
    logic byp_val;
    logic byp_en;
  } lock_cfg_t;

  localparam int CFG_W = $bits(det_cfg_t);

  localparam det_cfg_t DET_RST = '{
    force_ok: 1'b0,
    det_en:   1'b0,
    exp_cnt:  8'h80,
    win_len:  5'h0D
  };

endpackage

// File: rtl/clkdet_rst_sync.sv
module clkdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkdet_bit_sync.sv
module clkdet_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkdet_edge_counter.sv
module clkdet_edge_counter #(
  parameter int CNT_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_mon,
  input  logic             mon_rst_n,
  input  logic             req_tgl,
  output logic             ack_tgl,
  output logic [CNT_W-1:0] held_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             req_s;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             capture;

  clkdet_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk_mon), .rst_n(mon_rst_n), .d(req_tgl), .q(req_s)
  );

  assign capture = (req_s != ack_q);

  always_comb begin
    ack_d  = req_s;
    hold_d = hold_q;
    if (capture) begin
      hold_d = cnt_q;
      cnt_d  = CNT_ONE;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d  = CNT_MAX;
    end else begin
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_mon or negedge mon_rst_n) begin
    if (!mon_rst_n) begin
      ack_q  <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      ack_q  <= ack_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign ack_tgl  = ack_q;
  assign held_cnt = hold_q;

  // R4: a full counter stays full until the next capture
  a_r4_no_wrap: assert property (@(posedge clk_mon) disable iff (!mon_rst_n)
    (cnt_q == CNT_MAX && !capture) |=> (cnt_q == CNT_MAX));

  // R11: the held count only moves on a capture, so it is stable while the reference side reads it
  a_r11_hold_stable: assert property (@(posedge clk_mon) disable iff (!mon_rst_n)
    !capture |=> $stable(hold_q));
endmodule

// File: rtl/clkdet_window_timer.sv
module clkdet_window_timer #(
  parameter int LEN_W    = 5,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] win_len,
  output logic             win_end
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int GAP_W = PRE_W + LEN_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LEN_W-1:0] wcnt_q, wcnt_d;
  logic [LEN_W-1:0] len_eff;
  logic             tick, last;

  assign len_eff = (win_len == '0) ? LEN_W'(1) : win_len;
  assign tick    = (pre_q == PRE_LAST);
  assign last    = (wcnt_q == len_eff - LEN_W'(1));
  assign win_end = run && tick && last;

  always_comb begin
    pre_d  = pre_q;
    wcnt_d = wcnt_q;
    if (!run) begin
      pre_d  = '0;
      wcnt_d = '0;
    end else if (tick) begin
      pre_d  = '0;
      wcnt_d = last ? '0 : wcnt_q + LEN_W'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      wcnt_q <= '0;
    end else begin
      pre_q  <= pre_d;
      wcnt_q <= wcnt_d;
    end
  end

  // R2: cycles elapsed since the run started or the last window end
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (!run || win_end)  gap_q <= '0;
    else                       gap_q <= gap_q + GAP_W'(1);
  end

  a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> (gap_q == GAP_W'(PRESCALE * int'(len_eff) - 1)));
endmodule

// File: rtl/clk_presence_mon.sv
module clk_presence_mon
  import clkdet_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int STAGES   = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clk_mon,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             pll_lock_in,
  output logic             clk_ok,
  output logic             pll_lock
);
  localparam int LOCK_W = $bits(lock_cfg_t);
  localparam logic [1:0] WARM_DONE = 2'd2;

  logic ref_rst_n, mon_rst_n;

  clkdet_rst_sync #(.STAGES(STAGES)) u_ref_rst (
    .clk(clk_ref), .arst_n(rst_n), .rst_n_o(ref_rst_n)
  );
  clkdet_rst_sync #(.STAGES(STAGES)) u_mon_rst (
    .clk(clk_mon), .arst_n(rst_n), .rst_n_o(mon_rst_n)
  );

  // configuration words
  det_cfg_t  det_q, det_d, det_new;
  lock_cfg_t lck_q, lck_d;
  logic      restart_q, restart_d;

  assign det_new = det_cfg_t'(cfg_wdata);

  always_comb begin
    det_d     = det_q;
    lck_d     = lck_q;
    restart_d = 1'b0;
    if (cfg_wr && !cfg_sel) begin
      det_d     = det_new;
      restart_d = det_new.det_en && det_q.det_en &&
                  ((det_new.win_len != det_q.win_len) ||
                   (det_new.exp_cnt != det_q.exp_cnt));
    end
    if (cfg_wr && cfg_sel) lck_d = lock_cfg_t'(cfg_wdata[LOCK_W-1:0]);
  end

  assign cfg_rdata = cfg_sel ? {{(CFG_W-LOCK_W){1'b0}}, lck_q} : det_q;

  // window timer
  logic win_end;

  clkdet_window_timer #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk_ref), .rst_n(ref_rst_n),
    .run(det_q.det_en && !restart_q),
    .win_len(det_q.win_len), .win_end(win_end)
  );

  // count transfer handshake
  logic             req_q, req_d;
  logic             ack_tgl, ack_s, ack_s_d;
  logic [CNT_W-1:0] held_cnt, cap_q, cap_d, cmp_cnt;
  logic             pending, arrive;

  clkdet_edge_counter #(.CNT_W(CNT_W), .STAGES(STAGES)) u_counter (
    .clk_mon(clk_mon), .mon_rst_n(mon_rst_n), .req_tgl(req_q),
    .ack_tgl(ack_tgl), .held_cnt(held_cnt)
  );

  clkdet_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk_ref), .rst_n(ref_rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign pending = (req_q != ack_s);
  assign arrive  = (ack_s != ack_s_d);
  assign cmp_cnt = arrive ? held_cnt : cap_q;

  // decision
  logic [1:0] warm_q, warm_d;
  logic       ok_q, ok_d;

  always_comb begin
    cap_d  = cmp_cnt;
    req_d  = req_q;
    warm_d = warm_q;
    ok_d   = ok_q;
    if (!det_q.det_en) begin
      ok_d   = 1'b0;
      warm_d = '0;
    end else if (restart_q) begin
      warm_d = '0;
    end else if (win_end) begin
      if (pending) begin
        ok_d = 1'b0;
      end else begin
        req_d = ~req_q;
        if (warm_q == WARM_DONE) ok_d   = (cmp_cnt >= det_q.exp_cnt);
        else                     warm_d = warm_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_ref or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      det_q     <= DET_RST;
      lck_q     <= '0;
      restart_q <= 1'b0;
      req_q     <= 1'b0;
      ack_s_d   <= 1'b0;
      cap_q     <= '0;
      warm_q    <= '0;
      ok_q      <= 1'b0;
    end else begin
      det_q     <= det_d;
      lck_q     <= lck_d;
      restart_q <= restart_d;
      req_q     <= req_d;
      ack_s_d   <= ack_s;
      cap_q     <= cap_d;
      warm_q    <= warm_d;
      ok_q      <= ok_d;
    end
  end

  assign clk_ok   = ok_q || det_q.force_ok;
  assign pll_lock = lck_q.byp_en ? lck_q.byp_val : pll_lock_in;

  // R7: the measured flag holds between window ends while enabled
  a_r7_hold_between: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
    (det_q.det_en && !win_end) |=> $stable(ok_q));

  // R5: disabled detection clears the measured flag on the next edge
  a_r5_disabled_clear: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
    !det_q.det_en |=> !ok_q);

  // R11: a request toggles only when the previous one was acknowledged
  a_r11_one_outstanding: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
    !$stable(req_q) |-> $past(ack_s == req_q));

  // R9: a restart never publishes a result in the following cycle
  a_r9_restart_holds: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
    (restart_q && det_q.det_en) |=> $stable(ok_q));
endmodule

// File: tb/clk_presence_mon_bench.sv
`timescale 1ns/1ps
module clk_presence_mon_bench;
  localparam int CFG_W = 15;

  logic             clk_ref = 1'b0;
  logic             clk_mon = 1'b0;
  logic             rst_n;
  logic             cfg_wr;
  logic             cfg_sel;
  logic [CFG_W-1:0] cfg_wdata;
  logic [CFG_W-1:0] cfg_rdata;
  logic             pll_lock_in;
  logic             clk_ok;
  logic             pll_lock;

  int      n_chk  = 0;
  int      n_fail = 0;
  bit      done   = 1'b0;
  bit      mon_run = 1'b1;
  realtime mon_half = 2.5;

  clk_presence_mon u_clk_presence_mon (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_mon(clk_mon),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pll_lock_in(pll_lock_in),
    .clk_ok(clk_ok), .pll_lock(pll_lock)
  );

  always #4 clk_ref = ~clk_ref;

  always begin
    if (mon_run) begin
      #(mon_half) clk_mon = ~clk_mon;
    end else begin
      #1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  task automatic wr(input logic sel, input logic [CFG_W-1:0] d);
    @(negedge clk_ref);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk_ref);
    cfg_wr = 1'b0; cfg_sel = 1'b0;
  endtask

  function automatic logic [CFG_W-1:0] det_word(input logic frc, input logic en,
                                                input int expv, input int len);
    return {frc, en, 8'(expv), 5'(len)};
  endfunction

  function automatic int win_cycles(input int len);
    return 8 * ((len == 0) ? 1 : len);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int per_ps[4];
    int lens[4];
    per_ps = '{3000, 5000, 7000, 11000};
    lens   = '{0, 2, 4, 13};
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; pll_lock_in = 1'b0;
    cycles(5);
    rst_n = 1'b1;
    cycles(5);

    // R1 reset state
    cfg_sel = 1'b0; #1;
    check(cfg_rdata, 15'h100D, "R1 detector word reset");
    cfg_sel = 1'b1; #1;
    check(cfg_rdata, 15'h0000, "R1 lock word reset");
    cfg_sel = 1'b0;
    check(clk_ok, 1'b0, "R1 clk_ok reset");

    // R10 lock bypass
    pll_lock_in = 1'b1; cycles(1);
    check(pll_lock, 1'b1, "R10 pass-through high");
    wr(1'b1, 15'h0001); cycles(1);
    check(pll_lock, 1'b0, "R10 forced low");
    pll_lock_in = 1'b0;
    wr(1'b1, 15'h0003); cycles(1);
    check(pll_lock, 1'b1, "R10 forced high");
    wr(1'b1, 15'h0002); cycles(1);
    check(pll_lock, 1'b0, "R10 value ignored when disabled");
    cfg_sel = 1'b1; #1;
    check(cfg_rdata, 15'h0002, "R10 lock word readback");
    cfg_sel = 1'b0;

    // R7 first result at end of third window (len 4, 5 ns clock: 51 edges)
    mon_half = 2.5;
    wr(1'b0, det_word(1'b0, 1'b1, 38, 4));
    cycles(80);
    check(clk_ok, 1'b0, "R7 not published before third window end");
    cycles(32);
    check(clk_ok, 1'b1, "R7 published at third window end");

    // R9 restart keeps old value, then republishes
    wr(1'b0, det_word(1'b0, 1'b1, 64, 4));
    cycles(48);
    check(clk_ok, 1'b1, "R9 value held through restart");
    cycles(112);
    check(clk_ok, 1'b0, "R9 new expected count applied");

    // R5 disable clears
    wr(1'b0, det_word(1'b0, 1'b1, 38, 4));
    cycles(170);
    check(clk_ok, 1'b1, "R5 enabled baseline");
    wr(1'b0, det_word(1'b0, 1'b0, 38, 4));
    cycles(1);
    check(clk_ok, 1'b0, "R5 cleared when disabled");

    // R8 force-ok
    wr(1'b0, det_word(1'b1, 1'b0, 38, 4));
    cycles(1);
    check(clk_ok, 1'b1, "R8 forced with detection off");
    wr(1'b0, det_word(1'b1, 1'b1, 250, 4));
    cycles(170);
    check(clk_ok, 1'b1, "R8 forced over failing measurement");
    wr(1'b0, det_word(1'b0, 1'b0, 38, 4));
    cycles(1);
    check(clk_ok, 1'b0, "R8 force released");

    // R6 stopped clock
    wr(1'b0, det_word(1'b0, 1'b1, 38, 4));
    cycles(170);
    check(clk_ok, 1'b1, "R6 running baseline");
    mon_run = 1'b0;
    cycles(80);
    check(clk_ok, 1'b0, "R6 stopped clock detected");
    mon_run = 1'b1;
    cycles(170);
    check(clk_ok, 1'b1, "R6 recovery after restart of clock");

    // R2 R3 R11 sweep over periods and window lengths
    foreach (per_ps[p]) begin
      foreach (lens[l]) begin
        int w, e, lo, hi;
        if (lens[l] == 0 && per_ps[p] > 5000) continue;
        mon_half = real'(per_ps[p]) / 2000.0;
        w  = win_cycles(lens[l]);
        e  = (w * 8000) / per_ps[p];
        lo = (e * 3) / 4;
        hi = (e * 5 + 3) / 4;
        if (lo > 255) lo = 255;
        wr(1'b0, det_word(1'b0, 1'b1, lo, lens[l]));
        cycles(5 * w + 10);
        check(clk_ok, 1'b1, $sformatf("R3 R2 R11 len %0d period %0d ps count above %0d",
                                      lens[l], per_ps[p], lo));
        if (hi <= 255) begin
          wr(1'b0, det_word(1'b0, 1'b1, hi, lens[l]));
          cycles(5 * w + 10);
          check(clk_ok, 1'b0, $sformatf("R3 R2 len %0d period %0d ps count below %0d",
                                        lens[l], per_ps[p], hi));
        end
      end
    end

    // R4 saturation: 277 edges per window against 255
    mon_half = 1.5;
    wr(1'b0, det_word(1'b0, 1'b1, 255, 13));
    cycles(5 * 104 + 10);
    check(clk_ok, 1'b1, "R4 saturated count meets 255");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule